// File: doc/BRIEF.md
# Dual-Output PWM Slice Counter

This block is one pulse-width slice: a single 16-bit counter feeds two comparators, and each comparator drives one output pin through its own polarity flip. The counter moves only on cycles where an external clock-enable strobe is high, so a separate divider sets the count rate. Two counting shapes are available. The sawtooth shape counts up from zero to the top value and restarts at zero. The triangle shape climbs to top and then descends to zero, which keeps each pulse centred in its period and halves the output rate.

The top value and both compare values are held in a shadow stage. A new setting is taken over only at a period boundary, so a pulse is never cut short or doubled. While the slice is disabled the shadow stage follows the inputs on every cycle, the counter is frozen and both pins sit at their idle level. A one-cycle strobe marks the end of every period.

Top module: `pwm_slice_top`

## Requirements
- R1: While enabled, a pin's compare result is 1 exactly when its active compare value is strictly greater than the current count.
- R2: An active compare value of 0 keeps the compare result at 0 for every count of the period.
- R3: An active compare value equal to top+1 keeps the compare result at 1 for every count of the period.
- R4: With `phase_mode` = 0 (sawtooth) the count runs 0,1,...,top and then returns to 0, so a period lasts top+1 enable strobes.
- R5: With `phase_mode` = 1 (triangle) the count runs 0 up to top, stays at top for one strobe while turning, runs down to 0 and stays at 0 for one strobe while turning, so a period lasts 2*(top+1) strobes and the high time (twice the compare value) is centred on count 0.
- R6: Each pin is its compare result XORed with its own invert input (1 = inverted), applied after the compare.
- R7: The counter changes only on clock cycles where both `en` and `tick` are 1.
- R8: While `en` is 0 the count holds, each pin equals its invert input, and the shadow stage loads the input top and compare values on every cycle.
- R9: While enabled, new top and compare inputs take effect only at the strobe that ends a period (the return to 0 in sawtooth, the turn at 0 in triangle).
- R10: `wrap` is high for exactly the one cycle that follows each strobe that ends a period, and low otherwise.
- R11: Synchronous reset clears the count, the turning direction (to up), the shadow values (to 0) and `wrap`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Slice enable |
| tick | input | 1 | Count-rate enable strobe from the divider |
| phase_mode | input | 1 | 0 = sawtooth, 1 = triangle |
| top_val | input | 16 | Requested top count |
| cmp_a | input | 16 | Requested compare value, pin A |
| cmp_b | input | 16 | Requested compare value, pin B |
| inv_a | input | 1 | Invert pin A |
| inv_b | input | 1 | Invert pin B |
| pwm_a | output | 1 | Pulse output A |
| pwm_b | output | 1 | Pulse output B |
| wrap | output | 1 | One-cycle end-of-period strobe |

## Verification
The hardest state to reach from the ports is a settings change that lands in the middle of a running period, because the shadow stage hides it until the boundary and only the pin pattern reveals which value is in force. The stimulus runs the counter to mid-period, rewrites the compare and top inputs to values that would flip the pin and move the wrap point, and checks that the old pattern and old period continue until the boundary and the new ones start right after it. A second directed sequence freezes the slice mid-period and changes settings while disabled, to show that the count resumes where it stopped while the shadow has taken the new values. The rest is a sweep of every compare value from 0 to top+1 over small top values in both shapes, with continuous and gapped enable strobes.

// File: rtl/pwm_slice_pkg.sv
package pwm_slice_pkg;

    localparam int CNT_W  = 16;
    localparam int NUM_CH = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        MODE_SAW = 1'b0,
        MODE_TRI = 1'b1
    } mode_e;

    // settings that pass through the shadow stage
    typedef struct packed {
        cnt_t                  top;
        cnt_t [NUM_CH-1:0]     cmp;
    } cfg_t;

    // result of one counter step
    typedef struct packed {
        cnt_t value;
        logic down;
        logic wrap;
    } step_t;

    function automatic step_t next_step(mode_e mode, cnt_t cur, logic down, cnt_t top);
        step_t s;
        s.value = cur;
        s.down  = 1'b0;
        s.wrap  = 1'b0;
        if (mode == MODE_SAW) begin
            if (cur >= top) begin
                s.value = '0;
                s.wrap  = 1'b1;
            end else begin
                s.value = cur + 1'b1;
            end
        end else if (!down) begin
            if (cur >= top) begin
                s.down = 1'b1;          // turn at top, hold for one step
            end else begin
                s.value = cur + 1'b1;
            end
        end else begin
            if (cur == '0) begin
                s.wrap = 1'b1;          // turn at zero, hold for one step
            end else begin
                s.value = cur - 1'b1;
                s.down  = 1'b1;
            end
        end
        return s;
    endfunction

    function automatic logic chan_level(cnt_t cmp, cnt_t cnt, logic inv, logic run);
        return run ? ((cmp > cnt) ^ inv) : inv;
    endfunction

endpackage

// File: rtl/pwm_slice_shadow.sv
module pwm_slice_shadow
    import pwm_slice_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cfg_t cfg_in,
    output cfg_t cfg_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else if (load) begin
            cfg_q <= cfg_in;
        end
    end

endmodule

// File: rtl/pwm_slice_counter.sv
module pwm_slice_counter
    import pwm_slice_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  logic  tick,
    input  mode_e mode,
    input  cnt_t  top,
    output cnt_t  cnt,
    output logic  boundary,
    output logic  wrap
);

    logic  down_q;
    step_t nx;

    always_comb begin
        nx = next_step(mode, cnt, down_q, top);
    end

    assign boundary = en && tick && nx.wrap;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            down_q <= 1'b0;
            wrap   <= 1'b0;
        end else begin
            wrap <= boundary;
            if (en && tick) begin
                cnt    <= nx.value;
                down_q <= nx.down;
            end
        end
    end

endmodule

// File: rtl/pwm_slice_channel.sv
module pwm_slice_channel
    import pwm_slice_pkg::*;
(
    input  cnt_t cmp,
    input  cnt_t cnt,
    input  logic inv,
    input  logic run,
    output logic pin
);

    assign pin = chan_level(cmp, cnt, inv, run);

endmodule

// File: rtl/pwm_slice_top.sv
module pwm_slice_top
    import pwm_slice_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 tick,
    input  logic                 phase_mode,
    input  logic [CNT_W-1:0]     top_val,
    input  logic [CNT_W-1:0]     cmp_a,
    input  logic [CNT_W-1:0]     cmp_b,
    input  logic                 inv_a,
    input  logic                 inv_b,
    output logic                 pwm_a,
    output logic                 pwm_b,
    output logic                 wrap
);

    cfg_t                cfg_in;
    cfg_t                cfg_q;
    cnt_t                cnt_q;
    logic                boundary;
    logic [NUM_CH-1:0]   inv_v;
    logic [NUM_CH-1:0]   pin_v;
    cnt_t                act_top;
    cnt_t                act_cmp_a;

    assign cfg_in.top    = top_val;
    assign cfg_in.cmp[0] = cmp_a;
    assign cfg_in.cmp[1] = cmp_b;
    assign inv_v         = {inv_b, inv_a};

    pwm_slice_shadow u_shadow (
        .clk    (clk),
        .rst    (rst),
        .load   (!en || boundary),
        .cfg_in (cfg_in),
        .cfg_q  (cfg_q)
    );

    pwm_slice_counter u_count (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .tick     (tick),
        .mode     (mode_e'(phase_mode)),
        .top      (cfg_q.top),
        .cnt      (cnt_q),
        .boundary (boundary),
        .wrap     (wrap)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_slice_channel u_chan (
            .cmp (cfg_q.cmp[ch]),
            .cnt (cnt_q),
            .inv (inv_v[ch]),
            .run (en),
            .pin (pin_v[ch])
        );
    end

    assign pwm_a     = pin_v[0];
    assign pwm_b     = pin_v[1];
    assign act_top   = cfg_q.top;
    assign act_cmp_a = cfg_q.cmp[0];

endmodule

// File: rtl/pwm_slice_checker.sv
module pwm_slice_checker
    import pwm_slice_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic en,
    input logic tick,
    input logic phase_mode,
    input logic inv_a,
    input logic inv_b,
    input logic pwm_a,
    input logic pwm_b,
    input logic wrap,
    input cnt_t cnt,
    input cnt_t act_top,
    input cnt_t act_cmp_a
);

    p_tick_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!en || !tick) |=> $stable(cnt));

    p_idle_pins_r8: assert property (@(posedge clk) disable iff (rst)
        !en |-> (pwm_a == inv_a && pwm_b == inv_b));

    p_zero_cmp_r2: assert property (@(posedge clk) disable iff (rst)
        (en && act_cmp_a == '0) |-> (pwm_a == inv_a));

    p_full_cmp_r3: assert property (@(posedge clk) disable iff (rst)
        (en && act_top != '1 && cnt <= act_top && act_cmp_a == act_top + 1'b1) |-> (pwm_a != inv_a));

    p_saw_step_r4: assert property (@(posedge clk) disable iff (rst)
        (en && tick && !phase_mode && cnt < act_top) |=> (cnt == $past(cnt) + 1'b1));

    p_wrap_src_r10: assert property (@(posedge clk) disable iff (rst)
        wrap |-> $past(en && tick));

    p_shadow_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (en && !tick) |=> $stable(act_top));

endmodule

bind pwm_slice_top pwm_slice_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .phase_mode (phase_mode),
    .inv_a      (inv_a),
    .inv_b      (inv_b),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .wrap       (wrap),
    .cnt        (cnt_q),
    .act_top    (act_top),
    .act_cmp_a  (act_cmp_a)
);

// File: tb/sim_pwm_slice_top.sv
`timescale 1ns/1ps
module sim_pwm_slice_top;

    logic        clk = 1'b0;
    logic        rst, en, tick, phase_mode, inv_a, inv_b;
    logic [15:0] top_val, cmp_a, cmp_b;
    logic        pwm_a, pwm_b, wrap;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pwm_slice_top u0 (
        .clk(clk), .rst(rst), .en(en), .tick(tick), .phase_mode(phase_mode),
        .top_val(top_val), .cmp_a(cmp_a), .cmp_b(cmp_b),
        .inv_a(inv_a), .inv_b(inv_b),
        .pwm_a(pwm_a), .pwm_b(pwm_b), .wrap(wrap)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    // advance n clock edges, then settle away from the edge
    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        #1;
    endtask

    function automatic int exp_count(input logic tri_m, input int top, input int ticks);
        int p;
        if (!tri_m) return ticks % (top + 1);
        p = ticks % (2 * (top + 1));
        return (p <= top) ? p : (2 * top + 1 - p);
    endfunction

    function automatic string pin_tag(input logic tri_m, input int top, input int c, input logic gap);
        string t;
        if (c == 0)            t = "R2";
        else if (c == top + 1) t = "R3";
        else if (tri_m)        t = "R5";
        else                   t = "R1/R4";
        if (gap) t = {t, "/R7"};
        return {t, "/R6"};
    endfunction

    task automatic run_cfg(input logic tri_m, input int top, input int ca, input logic gap);
        int cb, ticks, per, cnt;
        logic ia, ib, t_prev;
        cb = top + 1 - ca;
        ia = ca[0];
        ib = top[0];
        per = tri_m ? 2 * (top + 1) : top + 1;
        rst = 1'b1; en = 1'b0; tick = 1'b0; phase_mode = tri_m;
        top_val = 16'(top); cmp_a = 16'(ca); cmp_b = 16'(cb); inv_a = ia; inv_b = ib;
        step(1);
        rst = 1'b0;
        step(1);
        en = 1'b1;
        ticks = 0;
        tick = gap ? 1'b0 : 1'b1;
        #1;
        chk(pin_tag(tri_m, top, ca, gap), pwm_a, ((ca > 0) ? 1'b1 : 1'b0) ^ ia);
        chk("R10", wrap, 1'b0);
        for (int k = 1; k <= 3 * per + 4; k++) begin
            t_prev = tick;
            step(1);
            if (t_prev) ticks++;
            cnt = exp_count(tri_m, top, ticks);
            chk(pin_tag(tri_m, top, ca, gap), pwm_a, ((ca > cnt) ? 1'b1 : 1'b0) ^ ia);
            chk(pin_tag(tri_m, top, cb, gap), pwm_b, ((cb > cnt) ? 1'b1 : 1'b0) ^ ib);
            chk(tri_m ? "R10/R5" : "R10/R4", wrap, (t_prev && (ticks % per == 0)) ? 1'b1 : 1'b0);
            tick = gap ? ((k % 3) != 0) : 1'b1;
        end
        en = 1'b0; tick = 1'b0;
    endtask

    initial begin
        rst = 1'b1; en = 1'b1; tick = 1'b1; phase_mode = 1'b0;
        top_val = 16'd3; cmp_a = 16'd1; cmp_b = 16'd4; inv_a = 1'b0; inv_b = 1'b0;
        step(2);
        // R11: shadows cleared, so both compares read 0 during reset
        chk("R11", pwm_a, 1'b0);
        chk("R11", pwm_b, 1'b0);
        chk("R11", wrap, 1'b0);

        // sweep every compare value over small tops, both shapes
        for (int m = 0; m < 2; m++)
            for (int tp = 0; tp <= 4; tp++)
                for (int c = 0; c <= tp + 1; c++)
                    run_cfg(m[0], tp, c, tp[0]);

        // R8: freeze mid-period, change settings while disabled
        rst = 1'b1; en = 1'b0; tick = 1'b1; phase_mode = 1'b0;
        top_val = 16'd7; cmp_a = 16'd4; cmp_b = 16'd0; inv_a = 1'b0; inv_b = 1'b0;
        step(1); rst = 1'b0; step(1);
        en = 1'b1; step(2);                       // count now 2
        chk("R8 pre", pwm_a, 1'b1);
        en = 1'b0; #1;
        chk("R8 idle a", pwm_a, 1'b0);
        inv_a = 1'b1; inv_b = 1'b1; #1;
        chk("R8 idle a inv", pwm_a, 1'b1);
        chk("R8 idle b inv", pwm_b, 1'b1);
        inv_a = 1'b0; inv_b = 1'b0; cmp_b = 16'd3;
        step(3);
        en = 1'b1; tick = 1'b0; #1;
        chk("R8 count held", pwm_a, 1'b1);        // 4 > 2
        chk("R8 shadow loaded", pwm_b, 1'b1);     // 3 > 2
        tick = 1'b1; step(1);                     // count 3
        chk("R8 resume", pwm_b, 1'b0);
        step(4);                                  // 4,5,6,7
        chk("R8 no early wrap", wrap, 1'b0);
        step(1);                                  // back to 0
        chk("R8 wrap", wrap, 1'b1);

        // R9: settings change mid-period wait for the boundary
        rst = 1'b1; en = 1'b0; tick = 1'b1; phase_mode = 1'b0;
        top_val = 16'd7; cmp_a = 16'd2; cmp_b = 16'd0;
        step(1); rst = 1'b0; step(1);
        en = 1'b1; step(3);                       // count 3
        cmp_a = 16'd6; top_val = 16'd3;
        step(1);                                  // count 4
        chk("R9 old cmp kept", pwm_a, 1'b0);
        chk("R9 old top kept", wrap, 1'b0);
        step(3);                                  // 5,6,7
        chk("R9 no wrap before old top", wrap, 1'b0);
        step(1);                                  // 0
        chk("R9 wrap at old top", wrap, 1'b1);
        chk("R9 new cmp active", pwm_a, 1'b1);
        step(3);                                  // 1,2,3
        chk("R9 new top reached", wrap, 1'b0);
        step(1);                                  // 0
        chk("R9 wrap at new top", wrap, 1'b1);
        step(1);                                  // 1
        chk("R10 single cycle", wrap, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule